// File: doc/BRIEF.md
# DMA Channel Freeze Controller

This block keeps the freeze state of every channel of a multi-channel DMA engine and decides, side by side, whether the scheduler may issue transfers. Each channel has two freeze flags: one for its source side and one for its destination side. A flag blocks new issue on that side only. The channel's settings are not touched. Software changes the flags through a write-only bus port. A written 1 inverts a flag and a written 0 leaves it alone, so one write can freeze or release any set of channels together. A channel activation pulse from the scheduler releases both sides of that channel.

Issue requests pass through a short issue pipeline. A request that was admitted before a flag was set still leaves the pipeline as a grant. Once the pipeline has drained, the frozen side stays silent. DREQ requests keep being recorded while a channel is frozen. A per-channel pending flag holds each recorded request until a source-side grant for that channel consumes it. A debug view shows the flags and the pending bits.

Top module: `dma_freeze_ctrl`

## Requirements
- R1: After reset all freeze flags, all grants and all pending bits are 0.
- R2: A write with `wr_en` high and `wr_addr` equal to 0x214 inverts every freeze flag whose `wr_data` bit is 1. Flags whose bit is 0 keep their value. The new value is visible on `dbg_freeze` in the cycle after the write.
- R3: A write to any other address changes no freeze flag.
- R4: The source flag of channel x is `dbg_freeze` bit 2x and its destination flag is bit 2x+1. A source flag blocks only source grants, and a destination flag blocks only destination grants.
- R5: An `act_pulse` bit clears both flags of its channel in the next cycle. If a matching write targets the same channel in the same cycle, the clear wins.
- R6: A request on `src_req[x]` (or `dst_req[x]`) in cycle n, while that side's flag is 0 in cycle n, raises the matching grant in cycle n+2. Grants have no other cause.
- R7: A request admitted in the cycle in which a flag is being set still produces its grant. Requests made while the flag reads 1 produce no grant.
- R8: `dreq[x]` sets `pend[x]` in the next cycle, whatever the flags are. `pend[x]` stays set until a cycle with `src_grant[x]` high and `dreq[x]` low, after which it reads 0.
- R9: One write can change the flags of many channels at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Bus write offset |
| wr_data | input | 32 | Toggle mask, two bits per channel |
| act_pulse | input | 16 | Per-channel activation pulse |
| dreq | input | 16 | Per-channel DMA request |
| src_req | input | 16 | Source-side issue request per channel |
| dst_req | input | 16 | Destination-side issue request per channel |
| src_grant | output | 16 | Source-side issue grant per channel |
| dst_grant | output | 16 | Destination-side issue grant per channel |
| pend | output | 16 | Latched DREQ status per channel |
| dbg_freeze | output | 32 | Current freeze flags, interleaved source/destination |

## Verification
The hardest case to reach is the drain window. A request has to be admitted on the same clock edge that a write sets the flag, and the request must then be held through the following cycles. Only then does the grant that is already in flight show up while the flag reads 1, with the grants after it cut off. A directed sequence keeps `src_req` high through the toggling write and follows the grant edge by edge. The same sequence also freezes a source side while DREQ pulses arrive, then unfreezes it and watches the pending bit get consumed. A seeded random phase then mixes writes, misaddressed writes, activation pulses that collide with writes, and dense requests against a bench model.

// File: rtl/dfz_pkg.sv
package dfz_pkg;
   localparam int DFZ_MAX_CH    = 16;
   localparam int DFZ_MAX_STAGE = 4;
   typedef enum logic {SIDE_SRC = 1'b0, SIDE_DST = 1'b1} dfz_side_e;
endpackage

// File: rtl/dfz_state.sv
module dfz_state
   import dfz_pkg::*;
#(
   parameter int          NUM_CH     = 16,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] FRZ_OFFSET = 12'h214
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [2*NUM_CH-1:0]   wr_data,
   input  logic [NUM_CH-1:0]     act_pulse,
   output logic [2*NUM_CH-1:0]   frz
);
   logic wr_hit;
   assign wr_hit = wr_en && (wr_addr == FRZ_OFFSET[ADDR_W-1:0]);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (genvar sd = 0; sd < 2; sd++) begin : g_side
         localparam int BIT = 2*ch + sd;
         always_ff @(posedge clk) begin
            if (!rst_n)
               frz[BIT] <= 1'b0;
            else if (act_pulse[ch])
               frz[BIT] <= 1'b0;
            else if (wr_hit && wr_data[BIT])
               frz[BIT] <= ~frz[BIT];
         end
      end
   end
endmodule

// File: rtl/dfz_issue_pipe.sv
module dfz_issue_pipe
   import dfz_pkg::*;
#(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   input  logic [W-1:0] hold,
   output logic [W-1:0] grant
);
   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) grant <= '0;
         else        grant <= req & ~hold;
      end
   end else begin : g_multi
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= req & ~hold;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign grant = stg[STAGES-1];
   end
endmodule

// File: rtl/dfz_pending.sv
module dfz_pending #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dreq,
   input  logic [W-1:0] consume,
   output logic [W-1:0] pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= dreq | (pend & ~consume);
   end
endmodule

// File: rtl/dma_freeze_ctrl.sv
module dma_freeze_ctrl
   import dfz_pkg::*;
#(
   parameter int          NUM_CH     = 16,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] FRZ_OFFSET = 12'h214,
   parameter int          STAGES     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [2*NUM_CH-1:0] wr_data,
   input  logic [NUM_CH-1:0]   act_pulse,
   input  logic [NUM_CH-1:0]   dreq,
   input  logic [NUM_CH-1:0]   src_req,
   input  logic [NUM_CH-1:0]   dst_req,
   output logic [NUM_CH-1:0]   src_grant,
   output logic [NUM_CH-1:0]   dst_grant,
   output logic [NUM_CH-1:0]   pend,
   output logic [2*NUM_CH-1:0] dbg_freeze
);
   if (NUM_CH < 1 || NUM_CH > DFZ_MAX_CH) begin : g_bad_ch
      $error("dma_freeze_ctrl: NUM_CH out of range");
   end
   if (STAGES < 1 || STAGES > DFZ_MAX_STAGE) begin : g_bad_stg
      $error("dma_freeze_ctrl: STAGES out of range");
   end
   if (ADDR_W < 10 || ADDR_W > 12) begin : g_bad_addr
      $error("dma_freeze_ctrl: ADDR_W cannot hold the offset");
   end

   logic [2*NUM_CH-1:0] frz;
   logic [NUM_CH-1:0]   hold_src, hold_dst;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_split
      assign hold_src[ch] = frz[2*ch + int'(SIDE_SRC)];
      assign hold_dst[ch] = frz[2*ch + int'(SIDE_DST)];
   end

   dfz_state #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FRZ_OFFSET(FRZ_OFFSET)) i_state (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .act_pulse(act_pulse), .frz(frz));

   dfz_issue_pipe #(.W(NUM_CH), .STAGES(STAGES)) i_src_pipe (
      .clk(clk), .rst_n(rst_n), .req(src_req), .hold(hold_src), .grant(src_grant));

   dfz_issue_pipe #(.W(NUM_CH), .STAGES(STAGES)) i_dst_pipe (
      .clk(clk), .rst_n(rst_n), .req(dst_req), .hold(hold_dst), .grant(dst_grant));

   dfz_pending #(.W(NUM_CH)) i_pend (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .consume(src_grant), .pend(pend));

   assign dbg_freeze = frz;
endmodule

// File: rtl/dfz_checker.sv
module dfz_checker #(
   parameter int          NUM_CH     = 16,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] FRZ_OFFSET = 12'h214,
   parameter int          STAGES     = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [NUM_CH-1:0]   act_pulse,
   input logic [NUM_CH-1:0]   dreq,
   input logic [NUM_CH-1:0]   src_req,
   input logic [NUM_CH-1:0]   dst_req,
   input logic [NUM_CH-1:0]   src_grant,
   input logic [NUM_CH-1:0]   dst_grant,
   input logic [NUM_CH-1:0]   pend,
   input logic [2*NUM_CH-1:0] dbg_freeze
);
   logic hit;
   assign hit = wr_en && (wr_addr == FRZ_OFFSET[ADDR_W-1:0]);

   // R2 R3: flags move only on a matching write or an activation
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && act_pulse == '0) |=> $stable(dbg_freeze));

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      // R5
      p_act_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         act_pulse[ch] |=> (!dbg_freeze[2*ch] && !dbg_freeze[2*ch+1]));
      // R4 R7
      p_src_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
         dbg_freeze[2*ch] |-> ##STAGES !src_grant[ch]);
      p_dst_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
         dbg_freeze[2*ch+1] |-> ##STAGES !dst_grant[ch]);
      // R6
      p_src_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
         src_grant[ch] |-> $past(src_req[ch], STAGES));
      p_dst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
         dst_grant[ch] |-> $past(dst_req[ch], STAGES));
      // R8
      p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         dreq[ch] |=> pend[ch]);
      p_pend_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[ch] && !src_grant[ch]) |=> pend[ch]);
      p_pend_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (src_grant[ch] && !dreq[ch]) |=> !pend[ch]);
   end
endmodule

bind dma_freeze_ctrl dfz_checker #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FRZ_OFFSET(FRZ_OFFSET), .STAGES(STAGES)
) i_dfz_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .act_pulse(act_pulse), .dreq(dreq), .src_req(src_req), .dst_req(dst_req),
   .src_grant(src_grant), .dst_grant(dst_grant), .pend(pend),
   .dbg_freeze(dbg_freeze));

// File: tb/test_dma_freeze_ctrl.sv
module test_dma_freeze_ctrl;
   localparam int          NCH = 16;
   localparam logic [11:0] OFF = 12'h214;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [15:0] act_pulse = '0, dreq = '0, src_req = '0, dst_req = '0;
   logic [15:0] src_grant, dst_grant, pend;
   logic [31:0] dbg_freeze;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [31:0] m_frz;
   logic [15:0] m_s0, m_s1, m_d0, m_d1, m_pend;

   always #5 clk = ~clk;

   dma_freeze_ctrl #(.NUM_CH(NCH), .ADDR_W(12), .FRZ_OFFSET(OFF), .STAGES(2)) i_dma_freeze_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .act_pulse(act_pulse), .dreq(dreq), .src_req(src_req), .dst_req(dst_req),
      .src_grant(src_grant), .dst_grant(dst_grant), .pend(pend), .dbg_freeze(dbg_freeze));

   function automatic logic [15:0] even_bits(input logic [31:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[2*i];
      return r;
   endfunction
   function automatic logic [15:0] odd_bits(input logic [31:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[2*i+1];
      return r;
   endfunction
   function automatic logic [31:0] spread(input logic [15:0] a);
      logic [31:0] r;
      for (int i = 0; i < 16; i++) begin r[2*i] = a[i]; r[2*i+1] = a[i]; end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; wr_addr = OFF; wr_data = '0;
      act_pulse = '0; dreq = '0; src_req = '0; dst_req = '0;
   endtask

   // One clock: update the model from the inputs held over the edge, then compare.
   task automatic cyc();
      logic [31:0] nf;
      logic [15:0] np;
      @(posedge clk);
      #1;
      if (!rst_n) begin
         m_frz = '0; m_s0 = '0; m_s1 = '0; m_d0 = '0; m_d1 = '0; m_pend = '0;
      end else begin
         nf = m_frz;
         if (wr_en && wr_addr == OFF) nf = nf ^ wr_data;
         nf = nf & ~spread(act_pulse);
         np = dreq | (m_pend & ~m_s1);
         m_s1 = m_s0; m_s0 = src_req & ~even_bits(m_frz);
         m_d1 = m_d0; m_d0 = dst_req & ~odd_bits(m_frz);
         m_frz = nf; m_pend = np;
      end
      chk("R2 flags", dbg_freeze, m_frz);
      chk("R6 grants", {dst_grant, src_grant}, {m_d1, m_s1});
      chk("R8 pend", {16'h0, pend}, {16'h0, m_pend});
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1d));
      idle();
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1
      chk("R1 reset flags", dbg_freeze, 32'h0);
      chk("R1 reset out", {src_grant, dst_grant}, 32'h0);
      chk("R1 reset pend", {16'h0, pend}, 32'h0);

      // R2 toggle and write-zero
      wr(OFF, 32'h0000_0005);
      chk("R2 set", dbg_freeze, 32'h0000_0005);
      wr(OFF, 32'h0000_0004);
      chk("R2 toggle back", dbg_freeze, 32'h0000_0001);
      wr(OFF, 32'h0);
      chk("R2 zero no effect", dbg_freeze, 32'h0000_0001);

      // R3 other address
      wr(12'h224, 32'hFFFF_FFFF);
      chk("R3 miss", dbg_freeze, 32'h0000_0001);

      // R4 S0 frozen: dst side of ch0 still served, src not
      src_req = 16'h0001; dst_req = 16'h0001;
      repeat (3) cyc();
      chk("R4 src blocked", {16'h0, src_grant}, 32'h0);
      chk("R4 dst flows", {16'h0, dst_grant}, 32'h1);
      idle(); cyc(); cyc();

      // R5 activation beats a same-cycle write on ch0, ch1 still toggles
      act_pulse = 16'h0001;
      wr(OFF, 32'h0000_000F);
      act_pulse = '0;
      chk("R5 act wins", dbg_freeze, 32'h0000_000C);
      wr(OFF, 32'h0000_000C);
      chk("R5 cleanup", dbg_freeze, 32'h0);

      // R7 drain: ch2 source held requesting while S2 is set
      src_req = 16'h0004;
      cyc(); cyc();
      chk("R6 steady grant", {16'h0, src_grant}, 32'h4);
      wr(OFF, 32'h0000_0010);
      chk("R7 in flight", {16'h0, src_grant}, 32'h4);
      cyc();
      chk("R7 drained one", {16'h0, src_grant}, 32'h4);
      cyc();
      chk("R7 cut off", {16'h0, src_grant}, 32'h0);
      cyc();
      chk("R7 stays off", {16'h0, src_grant}, 32'h0);
      idle();

      // R8 DREQ kept while ch3 source frozen, consumed after release
      wr(OFF, 32'h0000_0050);           // toggles S2 off, S3 on
      dreq = 16'h0008; cyc(); dreq = '0;
      repeat (4) cyc();
      chk("R8 held while frozen", {16'h0, pend}, 32'h8);
      wr(OFF, 32'h0000_0040);
      src_req = 16'h0008; cyc(); src_req = '0;
      cyc();
      chk("R8 grant seen", {16'h0, src_grant}, 32'h8);
      cyc();
      chk("R8 consumed", {16'h0, pend}, 32'h0);

      // R9 many channels at once
      wr(OFF, 32'hAAAA_AAAA);
      chk("R9 all dst frozen", dbg_freeze, 32'hAAAA_AAAA);
      dst_req = 16'hFFFF; src_req = 16'hFFFF;
      repeat (3) cyc();
      chk("R9 no dst grants", {16'h0, dst_grant}, 32'h0);
      chk("R9 src grants", {16'h0, src_grant}, 32'hFFFF);
      idle();
      act_pulse = 16'hFFFF; cyc(); act_pulse = '0;
      chk("R5 all released", dbg_freeze, 32'h0);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         wr_en     = ($urandom % 5) == 0;
         wr_addr   = (($urandom % 4) == 0) ? 12'($urandom) : OFF;
         wr_data   = $urandom & $urandom;
         act_pulse = (($urandom % 6) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
         dreq      = 16'($urandom & $urandom & $urandom);
         src_req   = 16'($urandom);
         dst_req   = 16'($urandom);
         cyc();
      end
      idle();
      cyc();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule